// File: doc/BRIEF.md
# Microcoded 16-bit Processor Datapath

This block is the execution datapath of a small microprogrammed processor. One 32-bit horizontal control word is applied each clock cycle and fully determines that cycle's work. Two of sixteen 16-bit registers are read onto the left and right operand buses. The left operand, or the memory data buffer, goes through a four-function ALU and then a one-bit shifter. On the closing clock edge the result may be written back to a register, to the memory data buffer, or both. The memory address register may capture the right operand at the same edge.

Five of the sixteen registers hold constants: zero, one, minus one, a 12-bit address mask and an 8-bit byte mask. They take those values at reset and keep them, because write-back never reaches them. The microsequencer reads the negative and zero flags of the ALU result combinationally in the same cycle to make its branch decisions. The next-address and condition fields pass through the block unused. The memory side is a request interface: the address and write data come from registers, the read and write requests follow the control word, and a read-valid strobe tells the block when returned data can be captured.

Top module: `mdp_datapath`

## Requirements
- R1: After reset, mem_addr and mem_wdata are 0 and registers 0-4 and 10-15 read as 0. Registers 5, 6, 7, 8 and 9 read as 0x0000, 0x0001, 0xFFFF, 0x0FFF and 0x00FF respectively.
- R2: Control bits 28:27 choose the ALU function: 0 left+right (modulo 2^16), 1 left AND right, 2 left passed through, 3 bitwise NOT of left.
- R3: Control bits 26:25 choose the shifter: 0 no shift, 1 logical shift right by one with zero fill, 2 shift left by one with zero fill, 3 no shift.
- R4: Control bit 31 chooses the ALU left input: 0 takes the register selected by bits 11:8, 1 takes the memory data buffer (the value on mem_wdata).
- R5: When bit 20 is 1, the shifter output is written at the clock edge into the register indexed by bits 19:16. When bit 20 is 0, no register changes. Operands are read before the write, so a register that is both read and written in one cycle supplies its old value.
- R6: Writes aimed at registers 5 to 9 are ignored, and those registers keep their constant values.
- R7: When bit 23 is 1, the address register loads the low 12 bits of the right operand (register selected by bits 15:12). Otherwise it holds. It drives mem_addr.
- R8: When bit 24 is 1, the memory data buffer loads the shifter output. Otherwise it holds. It drives mem_wdata.
- R9: When bit 22 and mem_rvalid are both 1, the memory data buffer loads mem_rdata. This takes priority over bit 24 in the same cycle. Bit 22 without mem_rvalid loads nothing.
- R10: flag_n is bit 15 of the ALU output and flag_z is 1 when the ALU output is 0. Both are taken before the shifter and are valid in the same cycle as the control word.
- R11: mem_rd follows bit 22 and mem_wr follows bit 21 of the current control word.
- R12: Bits 30:29 and 7:0 have no effect on any output or register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ucode | input | 32 | Control word for the current cycle |
| mem_rdata | input | 16 | Data returned by memory |
| mem_rvalid | input | 1 | mem_rdata is valid this cycle |
| mem_addr | output | 12 | Address register contents |
| mem_wdata | output | 16 | Memory data buffer contents |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| flag_n | output | 1 | ALU result negative |
| flag_z | output | 1 | ALU result zero |

## Verification
The memory data buffer has two load sources that can meet in one cycle: returned memory data and the shifter result. The bench sets bit 24 and bit 22 together with mem_rvalid high, while the ALU computes a value that differs from mem_rdata. The following write data must equal mem_rdata. A second vector holds bit 22 high without the strobe and checks that the buffer does not change. Read-before-write within one instruction is provoked the same way: a register is used as an operand and as the write-back target together. Its later contents and the buffered result are then compared against the old-value sum.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

   localparam int CW_W   = 32;
   localparam int SEL_W  = 4;
   localparam int NREG   = 1 << SEL_W;

   // register indices; constants occupy a contiguous window
   localparam int REG_PC        = 0;
   localparam int REG_ACC       = 1;
   localparam int REG_STK       = 2;
   localparam int REG_INSN      = 3;
   localparam int REG_TMPI      = 4;
   localparam int REG_K_ZERO    = 5;
   localparam int REG_K_ONE     = 6;
   localparam int REG_K_ONES    = 7;
   localparam int REG_ADDR_MASK = 8;
   localparam int REG_BYTE_MASK = 9;
   localparam int REG_GP_FIRST  = 10;
   localparam int CONST_LO      = REG_K_ZERO;
   localparam int CONST_HI      = REG_BYTE_MASK;

   typedef enum logic [1:0] {
      ALU_ADD  = 2'd0,
      ALU_AND  = 2'd1,
      ALU_PASS = 2'd2,
      ALU_INV  = 2'd3
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_NONE  = 2'd0,
      SH_RIGHT = 2'd1,
      SH_LEFT  = 2'd2,
      SH_SPARE = 2'd3
   } shift_op_e;

   // field order follows the control word bit positions, MSB first
   typedef struct packed {
      logic                a_src;      // 31
      logic [1:0]          cond;       // 30:29
      alu_op_e             alu;        // 28:27
      shift_op_e           sh;         // 26:25
      logic                ld_buf;     // 24
      logic                ld_addr;    // 23
      logic                rd;         // 22
      logic                wr;         // 21
      logic                wb_en;      // 20
      logic [SEL_W-1:0]    c_sel;      // 19:16
      logic [SEL_W-1:0]    b_sel;      // 15:12
      logic [SEL_W-1:0]    a_sel;      // 11:8
      logic [7:0]          next_addr;  // 7:0
   } ucode_t;

endpackage

// File: rtl/mdp_regfile.sv
module mdp_regfile
   import mdp_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 12,
   parameter int BYTE_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  a_sel,
   input  logic [SEL_W-1:0]  b_sel,
   input  logic              we,
   input  logic [SEL_W-1:0]  w_sel,
   input  logic [DATA_W-1:0] w_data,
   output logic [DATA_W-1:0] a_data,
   output logic [DATA_W-1:0] b_data
);

   localparam int NPORT = 2;

   if (ADDR_W > DATA_W) begin : g_bad_mask
      $error("mdp_regfile: ADDR_W exceeds DATA_W");
   end
   if (BYTE_W > DATA_W) begin : g_bad_byte
      $error("mdp_regfile: BYTE_W exceeds DATA_W");
   end

   function automatic logic is_const(input int idx);
      return (idx >= CONST_LO) && (idx <= CONST_HI);
   endfunction

   function automatic logic [DATA_W-1:0] reset_val(input int idx);
      logic [DATA_W-1:0] v;
      case (idx)
         REG_K_ONE:     v = DATA_W'(1);
         REG_K_ONES:    v = '1;
         REG_ADDR_MASK: v = DATA_W'((64'd1 << ADDR_W) - 64'd1);
         REG_BYTE_MASK: v = DATA_W'((64'd1 << BYTE_W) - 64'd1);
         default:       v = '0;
      endcase
      return v;
   endfunction

   logic [DATA_W-1:0] rf_q [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            rf_q[i] <= reset_val(i);
         end
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (we && (int'(w_sel) == i) && !is_const(i)) begin
               rf_q[i] <= w_data;
            end
         end
      end
   end

   logic [SEL_W-1:0]  port_sel [NPORT];
   logic [DATA_W-1:0] port_dat [NPORT];

   assign port_sel[0] = a_sel;
   assign port_sel[1] = b_sel;

   for (genvar p = 0; p < NPORT; p++) begin : g_rd_port
      assign port_dat[p] = rf_q[port_sel[p]];
   end

   assign a_data = port_dat[0];
   assign b_data = port_dat[1];

endmodule

// File: rtl/mdp_alu.sv
module mdp_alu
   import mdp_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [DATA_W-1:0] res,
   output logic              neg,
   output logic              zero
);

   if (DATA_W < 2) begin : g_bad_w
      $error("mdp_alu: DATA_W must be at least 2");
   end

   always_comb begin
      unique case (op)
         ALU_ADD:  res = lhs + rhs;
         ALU_AND:  res = lhs & rhs;
         ALU_PASS: res = lhs;
         ALU_INV:  res = ~lhs;
         default:  res = lhs;
      endcase
   end

   assign neg  = res[DATA_W-1];
   assign zero = (res == '0);

endmodule

// File: rtl/mdp_shifter.sv
module mdp_shifter
   import mdp_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter bit ARITH_RIGHT = 1'b0
) (
   input  shift_op_e         op,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   logic fill_hi;

   if (ARITH_RIGHT) begin : g_arith
      assign fill_hi = din[DATA_W-1];
   end else begin : g_logic
      assign fill_hi = 1'b0;
   end

   always_comb begin
      unique case (op)
         SH_RIGHT: dout = {fill_hi, din[DATA_W-1:1]};
         SH_LEFT:  dout = {din[DATA_W-2:0], 1'b0};
         default:  dout = din;
      endcase
   end

endmodule

// File: rtl/mdp_memport.sv
module mdp_memport #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_addr,
   input  logic [DATA_W-1:0] addr_src,
   input  logic              ld_buf,
   input  logic [DATA_W-1:0] buf_src,
   input  logic              rd_req,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] buf_q
);

   logic take_mem;

   assign take_mem = rd_req && rd_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (ld_addr) begin
         addr_q <= addr_src[ADDR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
      end else if (take_mem) begin
         buf_q <= rd_data;
      end else if (ld_buf) begin
         buf_q <= buf_src;
      end
   end

endmodule

// File: rtl/mdp_datapath.sv
module mdp_datapath
   import mdp_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 12,
   parameter int BYTE_W      = 8,
   parameter bit ARITH_RIGHT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW_W-1:0]   ucode,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              flag_n,
   output logic              flag_z
);

   if ($bits(ucode_t) != CW_W) begin : g_bad_cw
      $error("mdp_datapath: control word layout is not CW_W bits");
   end

   ucode_t            uc;
   logic [DATA_W-1:0] a_lat;
   logic [DATA_W-1:0] b_lat;
   logic [DATA_W-1:0] alu_lhs;
   logic [DATA_W-1:0] alu_y;
   logic [DATA_W-1:0] shf_y;
   logic [DATA_W-1:0] buf_q;
   logic              unused_fields;

   assign uc            = ucode_t'(ucode);
   assign unused_fields = ^{uc.cond, uc.next_addr};

   mdp_regfile #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W)
   ) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_sel  (uc.a_sel),
      .b_sel  (uc.b_sel),
      .we     (uc.wb_en),
      .w_sel  (uc.c_sel),
      .w_data (shf_y),
      .a_data (a_lat),
      .b_data (b_lat)
   );

   assign alu_lhs = uc.a_src ? buf_q : a_lat;

   mdp_alu #(
      .DATA_W (DATA_W)
   ) u_alu (
      .op   (uc.alu),
      .lhs  (alu_lhs),
      .rhs  (b_lat),
      .res  (alu_y),
      .neg  (flag_n),
      .zero (flag_z)
   );

   mdp_shifter #(
      .DATA_W      (DATA_W),
      .ARITH_RIGHT (ARITH_RIGHT)
   ) u_shf (
      .op   (uc.sh),
      .din  (alu_y),
      .dout (shf_y)
   );

   mdp_memport #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_addr  (uc.ld_addr),
      .addr_src (b_lat),
      .ld_buf   (uc.ld_buf),
      .buf_src  (shf_y),
      .rd_req   (uc.rd),
      .rd_valid (mem_rvalid),
      .rd_data  (mem_rdata),
      .addr_q   (mem_addr),
      .buf_q    (buf_q)
   );

   assign mem_wdata = buf_q;
   assign mem_rd    = uc.rd;
   assign mem_wr    = uc.wr;

endmodule

// File: rtl/mdp_datapath_chk.sv
module mdp_datapath_chk
   import mdp_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CW_W-1:0]   ucode,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              mem_rvalid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              flag_n,
   input logic              flag_z,
   input logic [DATA_W-1:0] a_lat,
   input logic [DATA_W-1:0] b_lat,
   input logic [DATA_W-1:0] alu_y,
   input logic [DATA_W-1:0] shf_y
);

   ucode_t c;
   logic   mem_take;

   assign c        = ucode_t'(ucode);
   assign mem_take = c.rd && mem_rvalid;

   p_addr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      c.ld_addr |=> mem_addr == $past(b_lat[ADDR_W-1:0]));

   p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !c.ld_addr |=> $stable(mem_addr));

   p_buf_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_take |=> mem_wdata == $past(mem_rdata));

   p_buf_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (c.ld_buf && !mem_take) |=> mem_wdata == $past(shf_y));

   p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!c.ld_buf && !mem_take) |=> $stable(mem_wdata));

   p_noshift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (c.sh == SH_NONE || c.sh == SH_SPARE) |-> shf_y == alu_y);

   p_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (c.sh == SH_RIGHT) |-> shf_y[DATA_W-2:0] == alu_y[DATA_W-1:1]);

   p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!c.a_src && c.alu == ALU_PASS) |-> flag_z == (a_lat == '0));

   p_neg_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!c.a_src && c.alu == ALU_INV) |-> flag_n == !a_lat[DATA_W-1]);

   p_src_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (c.a_src && c.alu == ALU_PASS) |-> alu_y == mem_wdata);

   p_const_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!c.a_src && c.alu == ALU_PASS && int'(c.a_sel) == REG_K_ONE)
      |-> alu_y == DATA_W'(1));

endmodule

bind mdp_datapath mdp_datapath_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ucode      (ucode),
   .mem_rdata  (mem_rdata),
   .mem_rvalid (mem_rvalid),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .flag_n     (flag_n),
   .flag_z     (flag_z),
   .a_lat      (a_lat),
   .b_lat      (b_lat),
   .alu_y      (alu_y),
   .shf_y      (shf_y)
);

// File: tb/mdp_datapath_bench.sv
module mdp_datapath_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ucode = '0;
   logic [15:0] mem_rdata = '0;
   logic        mem_rvalid = 1'b0;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_rd, mem_wr, flag_n, flag_z;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mdp_datapath u_mdp_datapath (
      .clk(clk), .rst_n(rst_n), .ucode(ucode), .mem_rdata(mem_rdata),
      .mem_rvalid(mem_rvalid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .flag_n(flag_n), .flag_z(flag_z));

   typedef struct packed {
      logic       amux;  logic [1:0] cond; logic [1:0] alu; logic [1:0] sh;
      logic       ldb;   logic       lda;  logic       rd;  logic       wr;
      logic       enc;   logic [3:0] c;    logic [3:0] b;   logic [3:0] a;
      logic [7:0] nxt;   logic       rv;   logic [15:0] rdata;
      logic       en;    logic       ez;   logic [15:0] ewd; logic [11:0] ead;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VT [NV] = '{
      // amux cond alu sh ldb lda rd wr enc c b a nxt rv rdata n z wdata addr
      '{0,0,2,0,0,0,1,0,0, 0, 0, 5,8'h00,1,16'h1234,0,1,16'h1234,12'h000}, // R9 R10
      '{1,0,2,0,0,0,0,0,1,10, 0, 0,8'h00,0,16'h0000,0,0,16'h1234,12'h000}, // R4 R5
      '{0,0,0,0,1,1,0,0,1,11, 6,10,8'h00,0,16'h0000,0,0,16'h1235,12'h001}, // R2 R7 R8
      '{0,0,1,2,1,0,0,0,1,12, 8, 7,8'h00,0,16'h0000,0,0,16'h1FFE,12'h001}, // R2 R3
      '{0,0,3,1,1,1,0,0,1,13, 9, 5,8'h00,0,16'h0000,1,0,16'h7FFF,12'h0FF}, // R2 R3 R7
      '{0,0,2,3,1,0,0,0,0, 0, 0,12,8'h00,0,16'h0000,0,0,16'h1FFE,12'h0FF}, // R3 R5
      '{0,0,2,0,0,0,0,0,1, 6, 0, 7,8'h00,0,16'h0000,1,0,16'h1FFE,12'h0FF}, // R6 R8
      '{0,0,2,0,1,0,0,1,0, 0, 0, 6,8'h00,0,16'h0000,0,0,16'h0001,12'h0FF}, // R6 R11
      '{0,0,2,0,0,0,0,0,0,14, 0, 7,8'h00,0,16'h0000,1,0,16'h0001,12'h0FF}, // R5
      '{0,0,2,0,1,0,0,0,0, 0, 0,14,8'h00,0,16'h0000,0,1,16'h0000,12'h0FF}, // R5
      '{0,0,2,0,1,0,1,0,0, 0, 0, 6,8'h00,1,16'hABCD,0,0,16'hABCD,12'h0FF}, // R9
      '{0,0,2,0,0,0,1,0,0, 0, 0, 5,8'h00,0,16'h5555,0,1,16'hABCD,12'h0FF}, // R9
      '{0,0,0,0,1,0,0,0,1,10, 6,10,8'h00,0,16'h0000,0,0,16'h1235,12'h0FF}, // R5
      '{0,0,2,0,1,0,0,0,0, 0, 0,10,8'h00,0,16'h0000,0,0,16'h1235,12'h0FF}, // R5
      '{0,3,2,0,1,0,0,0,0, 0, 0,13,8'hFF,0,16'h0000,0,0,16'h7FFF,12'h0FF}, // R12
      '{1,0,0,0,1,0,0,0,0, 0, 6, 0,8'h00,0,16'h0000,1,0,16'h8000,12'h0FF}, // R4 R10
      '{0,0,0,0,1,0,0,0,0, 0, 6, 7,8'h00,0,16'h0000,0,1,16'h0000,12'h0FF}  // R2 R10
   };

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive pass-through of register idx into the data buffer, check after edge
   task automatic observe(input int idx, input logic [15:0] exp, input string req);
      @(negedge clk);
      ucode = {1'b0, 2'd0, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
               4'd0, 4'd0, 4'(idx), 8'd0};
      mem_rvalid = 1'b0;
      @(posedge clk); #1;
      chk(req, $sformatf("reg %0d", idx), mem_wdata, exp);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R1", "addr at reset", {4'h0, mem_addr}, 16'h0000);
      chk("R1", "wdata at reset", mem_wdata, 16'h0000);
      rst_n = 1'b1;
      observe(7,  16'hFFFF, "R1");
      observe(8,  16'h0FFF, "R1");
      observe(9,  16'h00FF, "R1");
      observe(5,  16'h0000, "R1");
      observe(0,  16'h0000, "R1");
      observe(15, 16'h0000, "R1");

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VT[i];
         @(negedge clk);
         ucode = {v.amux, v.cond, v.alu, v.sh, v.ldb, v.lda, v.rd, v.wr,
                  v.enc, v.c, v.b, v.a, v.nxt};
         mem_rdata  = v.rdata;
         mem_rvalid = v.rv;
         #2;
         chk("R10", $sformatf("vec %0d flag_n", i), {15'd0, flag_n}, {15'd0, v.en});
         chk("R10", $sformatf("vec %0d flag_z", i), {15'd0, flag_z}, {15'd0, v.ez});
         chk("R11", $sformatf("vec %0d mem_rd", i), {15'd0, mem_rd}, {15'd0, v.rd});
         chk("R11", $sformatf("vec %0d mem_wr", i), {15'd0, mem_wr}, {15'd0, v.wr});
         @(posedge clk); #1;
         chk("R8/R9", $sformatf("vec %0d wdata", i), mem_wdata, v.ewd);
         chk("R7", $sformatf("vec %0d addr", i), {4'h0, mem_addr}, {4'h0, v.ead});
      end

      // R6: constants survive a write attempt to every one of them
      for (int k = 5; k <= 9; k++) begin
         @(negedge clk);
         ucode = {1'b0, 2'd0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                  4'(k), 4'd0, 4'd5, 8'd0};
         mem_rvalid = 1'b0;
      end
      observe(5, 16'h0000, "R6");
      observe(6, 16'h0001, "R6");
      observe(7, 16'hFFFF, "R6");
      observe(8, 16'h0FFF, "R6");
      observe(9, 16'h00FF, "R6");

      // R1: reset in mid-run clears writable state
      @(negedge clk);
      ucode = '0;
      rst_n = 1'b0;
      #2;
      chk("R1", "wdata after reset", mem_wdata, 16'h0000);
      chk("R1", "addr after reset", {4'h0, mem_addr}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      observe(10, 16'h0000, "R1");
      observe(13, 16'h0000, "R1");
      observe(6,  16'h0001, "R1");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule